// File: doc/BRIEF.md
# Gateway Operating Mode Controller

This block is the supervisory state machine of a timing gateway. It decides whether the gateway's transfer sequencer may react to incoming events at all. Host commands arrive as a one-cycle strobe with a 3-bit code. Status inputs report the initialization result, the end of a configuration pass, fatal faults and recoverable (severe) faults. The block publishes its current state as a 3-bit code and drives an event-enable line that is high only while the gateway is operational.

The states are INIT (code 0), IDLE (1), CONFIGURING (2), CONFIGURED (3), OPREADY (4), STOPPING (5), ERROR (6) and FATAL (7). The transitions are:

- INIT→IDLE and INIT→FATAL, on the initialization result.
- IDLE→CONFIGURING, on the configure command.
- CONFIGURING→CONFIGURED, on the configuration done strobe.
- From CONFIGURED: to CONFIGURING on configure, to IDLE on idle, and to OPREADY on startop.
- OPREADY→STOPPING on stopop, then STOPPING→CONFIGURED automatically.
- Any non-FATAL state→ERROR, on a severe fault.
- Any non-FATAL state→FATAL, on a fatal fault.
- ERROR→IDLE, on recover.

With automatic recovery enabled, the block climbs ERROR→IDLE→CONFIGURING→CONFIGURED→OPREADY without any command. It still waits for the configuration done strobe during the climb.

A command that is not valid in the present state is dropped. The block reports it with a one-cycle illegal-command pulse.

Top module: `gw_mode_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, mode_state is 0 (INIT), evt_en is 0 and illegal_cmd is 0.
- R2: In INIT, init_done with init_ok=1 moves to IDLE (1). With init_ok=0 it moves to FATAL (7). Without init_done the state stays INIT.
- R3: FATAL is terminal: no command, severe fault or automatic recovery moves it, and every command there is flagged illegal.
- R4: In IDLE, only configure (code 1) is accepted and moves to CONFIGURING (2). Every other code leaves IDLE unchanged and is flagged.
- R5: CONFIGURING moves to CONFIGURED (3) on cfg_done and otherwise holds. cfg_done in any other state has no effect.
- R6: In CONFIGURED, configure (1) moves to CONFIGURING, idle (2) moves to IDLE, and startop (3) moves to OPREADY (4).
- R7: In OPREADY, stopop (4) moves to STOPPING (5). STOPPING moves to CONFIGURED in the next cycle without any command.
- R8: A severe fault moves any state except FATAL to ERROR (6). A fatal fault moves any state to FATAL and outranks a severe fault. Either fault outranks a command in the same cycle, and that command is not flagged.
- R9: In ERROR with automatic recovery off, the state holds until recover (5) moves it to IDLE.
- R10: In ERROR with autorec_en=1 the block steps to IDLE, then CONFIGURING, waits for cfg_done, enters CONFIGURED, and then moves to OPREADY. Commands during this climb are ignored and flagged.
- R11: A command with an invalid or unknown code (0, 6, 7) raises illegal_cmd for exactly the cycle after it and leaves the state unchanged.
- R12: evt_en is high exactly while mode_state is OPREADY, and is low in STOPPING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 3 | 1 configure, 2 idle, 3 startop, 4 stopop, 5 recover |
| init_done | input | 1 | Initialization result is valid |
| init_ok | input | 1 | Initialization succeeded |
| cfg_done | input | 1 | Configuration pass finished |
| fatal_err | input | 1 | Non-recoverable fault |
| severe_err | input | 1 | Recoverable severe fault |
| autorec_en | input | 1 | Enable automatic climb out of ERROR |
| mode_state | output | 3 | Current state code |
| evt_en | output | 1 | Transfer sequencer may react to events |
| illegal_cmd | output | 1 | One-cycle pulse for a rejected command |

## Verification
All outputs are registered. A wrong next-state decision therefore shows on mode_state at the very next clock edge, and evt_en moves on that same edge. The bench compares every cycle of each scripted sequence, so a misrouted transition cannot hide behind a later step. A wrong command judgement shows as an illegal_cmd pulse that is present when it should be absent, or absent when it should be present, one cycle after the command. A stuck recovery flag shows as a missing or extra step in the automatic climb.

// File: rtl/gw_mode_pkg.sv
package gw_mode_pkg;

    localparam int STATE_W = 3;
    localparam int CMD_W   = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_INIT   = 3'd0,
        ST_IDLE   = 3'd1,
        ST_CFGING = 3'd2,
        ST_CFGD   = 3'd3,
        ST_OPRDY  = 3'd4,
        ST_STOP   = 3'd5,
        ST_ERROR  = 3'd6,
        ST_FATAL  = 3'd7
    } gw_state_e;

    localparam logic [CMD_W-1:0] CMD_CONFIGURE = 3'd1;
    localparam logic [CMD_W-1:0] CMD_IDLE      = 3'd2;
    localparam logic [CMD_W-1:0] CMD_STARTOP   = 3'd3;
    localparam logic [CMD_W-1:0] CMD_STOPOP    = 3'd4;
    localparam logic [CMD_W-1:0] CMD_RECOVER   = 3'd5;

    typedef struct packed {
        logic      hit;
        gw_state_e target;
    } gw_cmd_res_t;

endpackage

// File: rtl/gw_cmd_check.sv
module gw_cmd_check
    import gw_mode_pkg::*;
(
    input  gw_state_e              state_i,
    input  logic                   climb_i,
    input  logic                   cmd_valid_i,
    input  logic [CMD_W-1:0]       cmd_i,
    output gw_cmd_res_t            res_o,
    output logic                   bad_o
);

    always_comb begin
        res_o.hit    = 1'b0;
        res_o.target = state_i;
        if (cmd_valid_i) begin
            unique case (state_i)
                ST_IDLE: begin
                    if (!climb_i && cmd_i == CMD_CONFIGURE) begin
                        res_o.hit    = 1'b1;
                        res_o.target = ST_CFGING;
                    end
                end
                ST_CFGD: begin
                    if (!climb_i) begin
                        if (cmd_i == CMD_CONFIGURE) begin
                            res_o.hit    = 1'b1;
                            res_o.target = ST_CFGING;
                        end else if (cmd_i == CMD_IDLE) begin
                            res_o.hit    = 1'b1;
                            res_o.target = ST_IDLE;
                        end else if (cmd_i == CMD_STARTOP) begin
                            res_o.hit    = 1'b1;
                            res_o.target = ST_OPRDY;
                        end
                    end
                end
                ST_OPRDY: begin
                    if (cmd_i == CMD_STOPOP) begin
                        res_o.hit    = 1'b1;
                        res_o.target = ST_STOP;
                    end
                end
                ST_ERROR: begin
                    if (cmd_i == CMD_RECOVER) begin
                        res_o.hit    = 1'b1;
                        res_o.target = ST_IDLE;
                    end
                end
                default: begin
                    res_o.hit    = 1'b0;
                    res_o.target = state_i;
                end
            endcase
        end
    end

    assign bad_o = cmd_valid_i && !res_o.hit;

endmodule

// File: rtl/gw_mode_fsm.sv
module gw_mode_fsm
    import gw_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_done_i,
    input  logic        init_ok_i,
    input  logic        cfg_done_i,
    input  logic        fatal_err_i,
    input  logic        severe_err_i,
    input  logic        autorec_en_i,
    input  gw_cmd_res_t res_i,
    output gw_state_e   state_o,
    output gw_state_e   nxt_o,
    output logic        climb_o,
    output logic        override_o
);

    gw_state_e state_q, state_n;
    logic      climb_q, climb_n;

    assign override_o = fatal_err_i || (severe_err_i && state_q != ST_FATAL);

    always_comb begin
        state_n = state_q;
        climb_n = climb_q;
        if (state_q != ST_FATAL && fatal_err_i) begin
            state_n = ST_FATAL;
            climb_n = 1'b0;
        end else if (state_q != ST_FATAL && severe_err_i) begin
            state_n = ST_ERROR;
            climb_n = 1'b0;
        end else begin
            unique case (state_q)
                ST_INIT:   if (init_done_i) state_n = init_ok_i ? ST_IDLE : ST_FATAL;
                ST_IDLE: begin
                    if (climb_q)        state_n = ST_CFGING;
                    else if (res_i.hit) state_n = res_i.target;
                end
                ST_CFGING: if (cfg_done_i) state_n = ST_CFGD;
                ST_CFGD: begin
                    if (climb_q) begin
                        state_n = ST_OPRDY;
                        climb_n = 1'b0;
                    end else if (res_i.hit) begin
                        state_n = res_i.target;
                    end
                end
                ST_OPRDY:  if (res_i.hit) state_n = res_i.target;
                ST_STOP:   state_n = ST_CFGD;
                ST_ERROR: begin
                    if (autorec_en_i) begin
                        state_n = ST_IDLE;
                        climb_n = 1'b1;
                    end else if (res_i.hit) begin
                        state_n = res_i.target;
                    end
                end
                ST_FATAL:  state_n = ST_FATAL;
                default:   state_n = ST_FATAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            climb_q <= 1'b0;
        end else begin
            state_q <= state_n;
            climb_q <= climb_n;
        end
    end

    assign state_o = state_q;
    assign nxt_o   = state_n;
    assign climb_o = climb_q;

    assert_fatal_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FATAL |=> state_q == ST_FATAL);

    assert_severe_to_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (severe_err_i && !fatal_err_i && state_q != ST_FATAL) |=> state_q == ST_ERROR);

    assert_fatal_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err_i |=> state_q == ST_FATAL);

    assert_stop_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STOP |=> (state_q == ST_CFGD || state_q == ST_ERROR || state_q == ST_FATAL));

    assert_idle_only_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !climb_q && !fatal_err_i && !severe_err_i &&
         !(res_i.hit)) |=> state_q == ST_IDLE);

endmodule

// File: rtl/gw_mode_out.sv
module gw_mode_out
    import gw_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  gw_state_e nxt_i,
    input  gw_state_e state_i,
    input  logic      bad_i,
    input  logic      override_i,
    output logic      evt_en_o,
    output logic      illegal_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_en_o  <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            evt_en_o  <= (nxt_i == ST_OPRDY);
            illegal_o <= bad_i && !override_i;
        end
    end

    assert_evt_en_matches_R12: assert property (@(posedge clk) disable iff (!rst_n)
        evt_en_o == (state_i == ST_OPRDY));

endmodule

// File: rtl/gw_mode_ctrl.sv
module gw_mode_ctrl
    import gw_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [CMD_W-1:0]   cmd_code,
    input  logic               init_done,
    input  logic               init_ok,
    input  logic               cfg_done,
    input  logic               fatal_err,
    input  logic               severe_err,
    input  logic               autorec_en,
    output logic [STATE_W-1:0] mode_state,
    output logic               evt_en,
    output logic               illegal_cmd
);

    gw_state_e   state_w, nxt_w;
    gw_cmd_res_t res_w;
    logic        bad_w, climb_w, override_w;

    gw_cmd_check u_check (
        .state_i     (state_w),
        .climb_i     (climb_w),
        .cmd_valid_i (cmd_valid),
        .cmd_i       (cmd_code),
        .res_o       (res_w),
        .bad_o       (bad_w)
    );

    gw_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_done_i  (init_done),
        .init_ok_i    (init_ok),
        .cfg_done_i   (cfg_done),
        .fatal_err_i  (fatal_err),
        .severe_err_i (severe_err),
        .autorec_en_i (autorec_en),
        .res_i        (res_w),
        .state_o      (state_w),
        .nxt_o        (nxt_w),
        .climb_o      (climb_w),
        .override_o   (override_w)
    );

    gw_mode_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_i      (nxt_w),
        .state_i    (state_w),
        .bad_i      (bad_w),
        .override_i (override_w),
        .evt_en_o   (evt_en),
        .illegal_o  (illegal_cmd)
    );

    assign mode_state = state_w;

    assert_illegal_follows_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |-> $past(cmd_valid));

    assert_init_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_INIT && init_done && !fatal_err && !severe_err)
        |=> (mode_state == 3'd1 || mode_state == 3'd7));

endmodule

// File: tb/gw_mode_ctrl_tb.sv
`timescale 1ns/1ps
module gw_mode_ctrl_tb;

    localparam logic [2:0] S_INIT = 3'd0, S_IDLE = 3'd1, S_CFGING = 3'd2, S_CFGD = 3'd3,
                           S_OPRDY = 3'd4, S_STOP = 3'd5, S_ERROR = 3'd6, S_FATAL = 3'd7;
    localparam logic [2:0] C_CFG = 3'd1, C_IDL = 3'd2, C_START = 3'd3, C_STOP = 3'd4, C_REC = 3'd5;
    // flag bits: {init_done, init_ok, cfg_done, fatal, severe, autorec}
    localparam logic [5:0] F_NONE = 6'b000000, F_INITOK = 6'b110000, F_INITBAD = 6'b100000,
                           F_CFGD = 6'b001000, F_FATAL = 6'b000100, F_SEV = 6'b000010,
                           F_AUTO = 6'b000001;

    typedef struct {
        logic [2:0] st;
        logic       en;
        logic       ill;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       init_done = 1'b0, init_ok = 1'b0, cfg_done = 1'b0;
    logic       fatal_err = 1'b0, severe_err = 1'b0, autorec_en = 1'b0;
    logic [2:0] mode_state;
    logic       evt_en, illegal_cmd;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    gw_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .init_done(init_done), .init_ok(init_ok), .cfg_done(cfg_done),
        .fatal_err(fatal_err), .severe_err(severe_err), .autorec_en(autorec_en),
        .mode_state(mode_state), .evt_en(evt_en), .illegal_cmd(illegal_cmd)
    );

    task automatic check3(input string tag, input logic [2:0] st, input logic en, input logic ill);
        n_tests++;
        if (mode_state !== st || evt_en !== en || illegal_cmd !== ill) begin
            n_fail++;
            $display("FAIL %s: state/en/ill actual %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, mode_state, evt_en, illegal_cmd, st, en, ill);
        end
    endtask

    // monitor: pops one expectation per clock, after the edge has settled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check3(e.tag, e.st, e.en, e.ill);
            end
        end
    end

    // driver: apply one cycle of stimulus and queue the expected outcome
    task automatic step(input logic cv, input logic [2:0] c, input logic [5:0] f,
                        input logic [2:0] st, input logic ill, input string tag);
        exp_t e;
        cmd_valid  = cv;
        cmd_code   = c;
        {init_done, init_ok, cfg_done, fatal_err, severe_err, autorec_en} = f;
        e.st  = st;
        e.en  = (st == S_OPRDY);
        e.ill = ill;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 3'd0;
        {init_done, init_ok, cfg_done, fatal_err, severe_err, autorec_en} = F_NONE;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check3("R1 in reset", S_INIT, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1 after reset", S_INIT, 1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(1, C_CFG,   F_NONE,   S_INIT,   1, "R11 cmd in INIT");
        step(0, 3'd0,    F_NONE,   S_INIT,   0, "R2 INIT holds");
        step(0, 3'd0,    F_INITOK, S_IDLE,   0, "R2 init ok");
        step(1, C_START, F_NONE,   S_IDLE,   1, "R4 startop in IDLE");
        step(1, 3'd7,    F_NONE,   S_IDLE,   1, "R11 unknown code");
        step(0, 3'd0,    F_CFGD,   S_IDLE,   0, "R5 cfg_done in IDLE");
        step(1, C_CFG,   F_NONE,   S_CFGING, 0, "R4 configure");
        step(1, C_START, F_NONE,   S_CFGING, 1, "R5 cmd while configuring");
        step(0, 3'd0,    F_NONE,   S_CFGING, 0, "R5 waits");
        step(0, 3'd0,    F_CFGD,   S_CFGD,   0, "R5 cfg_done");
        step(1, C_IDL,   F_NONE,   S_IDLE,   0, "R6 idle");
        step(1, C_CFG,   F_NONE,   S_CFGING, 0, "R4 configure again");
        step(0, 3'd0,    F_CFGD,   S_CFGD,   0, "R5 cfg_done again");
        step(1, C_CFG,   F_NONE,   S_CFGING, 0, "R6 reconfigure");
        step(0, 3'd0,    F_CFGD,   S_CFGD,   0, "R5 cfg_done");
        step(1, C_START, F_NONE,   S_OPRDY,  0, "R6 R12 startop");
        step(1, C_START, F_NONE,   S_OPRDY,  1, "R11 startop in OPREADY");
        step(1, 3'd0,    F_NONE,   S_OPRDY,  1, "R11 code 0");
        step(1, C_STOP,  F_NONE,   S_STOP,   0, "R7 R12 stopop");
        step(0, 3'd0,    F_NONE,   S_CFGD,   0, "R7 auto to CONFIGURED");
        step(1, C_START, F_NONE,   S_OPRDY,  0, "R6 startop");
        step(1, C_STOP,  F_SEV,    S_ERROR,  0, "R8 severe beats cmd");
        step(1, C_START, F_NONE,   S_ERROR,  1, "R9 startop in ERROR");
        step(0, 3'd0,    F_NONE,   S_ERROR,  0, "R9 holds");
        step(1, C_REC,   F_NONE,   S_IDLE,   0, "R9 recover");
        step(1, C_CFG,   F_NONE,   S_CFGING, 0, "R4 configure");
        step(0, 3'd0,    F_SEV,    S_ERROR,  0, "R8 severe in CONFIGURING");
        step(0, 3'd0,    F_AUTO,   S_IDLE,   0, "R10 climb to IDLE");
        step(1, C_CFG,   F_NONE,   S_CFGING, 1, "R10 cmd in climb");
        step(0, 3'd0,    F_NONE,   S_CFGING, 0, "R10 waits cfg");
        step(0, 3'd0,    F_CFGD,   S_CFGD,   0, "R10 cfg_done");
        step(1, C_IDL,   F_NONE,   S_OPRDY,  1, "R10 climb to OPREADY");
        step(1, C_REC,   F_FATAL | F_SEV, S_FATAL, 0, "R8 fatal beats severe");
        step(1, C_REC,   F_NONE,   S_FATAL,  1, "R3 recover in FATAL");
        step(0, 3'd0,    F_SEV,    S_FATAL,  0, "R3 severe in FATAL");
        step(0, 3'd0,    F_AUTO,   S_FATAL,  0, "R3 autorec in FATAL");
        do_reset();
        step(0, 3'd0,    F_INITBAD, S_FATAL, 0, "R2 init failure");
        step(1, C_CFG,   F_NONE,   S_FATAL,  1, "R3 configure in FATAL");
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule